// File: doc/BRIEF.md
# Pin-Change and External Interrupt Flag Controller

This block watches thirty-two input pins, organised as four groups of eight, and one separate external interrupt pin. Every input first goes through a two-flop synchroniser. A pin change is found by comparing the synchronised value with the value it had one clock earlier. Each pin has a mask bit. A change on a pin whose mask bit is set raises a sticky flag for that pin's group, but only while the group's enable bit is set. A group presents an interrupt request while its flag, its enable bit and a global interrupt enable input are all high.

Software reaches the masks, the enables, the flags and the external-pin sense control over a byte-wide register bus made of address, write strobe, write data and registered read data. A flag clears in two ways: software writes a one to its bit, or the interrupt consumer acknowledges the vector on a small acknowledge port that carries a source index. The external pin can detect any change, a falling edge or a rising edge. It also has a level mode, in which its flag is held clear and its request follows the pin directly.

Top module: `pcint_ctrl`

## Requirements
- R1: After reset, every mask, enable, flag and sense register reads zero, and `irq` is zero.
- R2: A rising or falling change on pin `8*g+p` sets flag bit `g+1` of the flag register (address 0x3C). This happens only when mask bit `p` of group `g` and enable bit `g+1` of the enable register (address 0x3D) are both set.
- R3: A change on a pin whose mask bit is clear leaves every flag unchanged. A change in a group whose enable bit is clear also leaves every flag unchanged.
- R4: `irq[i]` is high only while flag bit `i`, enable bit `i` and `glb_ie` are all high. It is registered, so it lags them by one clock.
- R5: Writing the flag register clears each flag whose write-data bit is one. Flags whose write-data bit is zero are left unchanged.
- R6: An acknowledge (`ack_valid` high) clears only the flag selected by `ack_idx`. Index 0 selects the external pin and index `g+1` selects group `g`. An index above 4 changes no flag.
- R7: When a flag is set and cleared in the same cycle, whether by write-one-to-clear or by acknowledge, the flag ends up set.
- R8: In the external-pin sense field (bits 1:0 at address 0x69), the codes select the edge that sets flag bit 0 while enable bit 0 is set: 01 sets it on any change, 10 on a falling edge only, and 11 on a rising edge only.
- R9: Sense code 00 is level mode. In this mode flag bit 0 reads zero, and `irq[0]` is high while enable bit 0 and `glb_ie` are set and the synchronised external pin is low.
- R10: The four mask registers for groups 0, 1, 2 and 3 are at addresses 0x6B, 0x6C, 0x6D and 0x73. Bit 7 of the group 3 mask always reads zero, so pin 31 can never set a flag. An unmapped address reads zero. `bus_rdata` shows the register at the address presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins | input | 32 | Watched pins; pin 8*g+p is bit p of group g |
| ext_pin | input | 1 | Separate external interrupt pin |
| glb_ie | input | 1 | Global interrupt enable |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ack_valid | input | 1 | Vector acknowledge strobe |
| ack_idx | input | 3 | Index of the acknowledged source |
| irq | output | 5 | Requests: bit 0 is the external pin, bit g+1 is group g |

## Verification
The hardest case to reach is a set and a clear arriving on the same clock. To produce it, the bench counts the two synchroniser stages and the compare stage. It drives a pin change, then asserts the flag-clearing write, or the acknowledge, exactly three edges later, while the flag is already high. That is the edge on which the detected change lands. Beyond that, the bench sweeps every pin of every group, in both directions, with the mask bit on and off, the group enable on and off, and the global enable alternating. The mask register is loaded with every other pin enabled, so a change leaking in from a neighbouring pin would also show up.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'b00,
    SENSE_ANY   = 2'b01,
    SENSE_FALL  = 2'b10,
    SENSE_RISE  = 2'b11
  } sense_e;
endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pcint_detect.sv
module pcint_detect #(
  parameter int NG = 4,
  parameter int GW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NG*GW-1:0] pins_s,
  input  logic           ext_s,
  input  logic [NG*GW-1:0] mask,
  input  logic [1:0]     sense,
  output logic [NG-1:0]  grp_hit,
  output logic           ext_hit
);
  import pcint_pkg::*;

  logic [NG*GW-1:0] prev;
  logic             ext_prev;
  logic [NG*GW-1:0] chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev     <= '0;
      ext_prev <= 1'b0;
    end else begin
      prev     <= pins_s;
      ext_prev <= ext_s;
    end
  end

  assign chg = pins_s ^ prev;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_hit[g] = |(chg[g*GW +: GW] & mask[g*GW +: GW]);
  end

  always_comb begin
    unique case (sense_e'(sense))
      SENSE_ANY:  ext_hit = ext_s ^ ext_prev;
      SENSE_FALL: ext_hit = ext_prev & ~ext_s;
      SENSE_RISE: ext_hit = ext_s & ~ext_prev;
      default:    ext_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcint_regs.sv
module pcint_regs #(
  parameter int              NG        = 4,
  parameter int              GW        = 8,
  parameter int              TOP_BITS  = 7,
  parameter logic [NG*8-1:0] MASK_ADDR = {8'h73, 8'h6D, 8'h6C, 8'h6B},
  parameter logic [7:0]      ENA_ADDR  = 8'h3D,
  parameter logic [7:0]      FLG_ADDR  = 8'h3C,
  parameter logic [7:0]      SNS_ADDR  = 8'h69
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       addr,
  input  logic             we,
  input  logic [7:0]       wdata,
  input  logic [NG:0]      flags_in,
  output logic [NG*GW-1:0] mask,
  output logic [NG:0]      ena,
  output logic [1:0]       sense,
  output logic [NG:0]      w1c,
  output logic [7:0]       rdata
);
  localparam int NS = NG + 1;

  function automatic logic [GW-1:0] keep_of(int g);
    if (g == NG - 1) return GW'((1 << TOP_BITS) - 1);
    return '1;
  endfunction

  for (genvar g = 0; g < NG; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst) mask[g*GW +: GW] <= '0;
      else if (we && addr == MASK_ADDR[g*8 +: 8])
        mask[g*GW +: GW] <= wdata[GW-1:0] & keep_of(g);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ena   <= '0;
      sense <= '0;
    end else if (we) begin
      if (addr == ENA_ADDR) ena   <= wdata[NS-1:0];
      if (addr == SNS_ADDR) sense <= wdata[1:0];
    end
  end

  assign w1c = (we && addr == FLG_ADDR) ? wdata[NS-1:0] : '0;

  logic [7:0] rd_n;
  always_comb begin
    rd_n = '0;
    for (int g = 0; g < NG; g++)
      if (addr == MASK_ADDR[g*8 +: 8]) rd_n[GW-1:0] = mask[g*GW +: GW];
    if (addr == ENA_ADDR) rd_n[NS-1:0] = ena;
    if (addr == FLG_ADDR) rd_n[NS-1:0] = flags_in;
    if (addr == SNS_ADDR) rd_n[1:0]    = sense;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end
endmodule

// File: rtl/pcint_ctrl.sv
module pcint_ctrl #(
  parameter int              NG        = 4,
  parameter int              GW        = 8,
  parameter int              TOP_BITS  = 7,
  parameter int              SYNC      = 2,
  parameter logic [NG*8-1:0] MASK_ADDR = {8'h73, 8'h6D, 8'h6C, 8'h6B},
  parameter logic [7:0]      ENA_ADDR  = 8'h3D,
  parameter logic [7:0]      FLG_ADDR  = 8'h3C,
  parameter logic [7:0]      SNS_ADDR  = 8'h69,
  localparam int             NS        = NG + 1,
  localparam int             IDX_W     = $clog2(NS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NG*GW-1:0] pins,
  input  logic             ext_pin,
  input  logic             glb_ie,
  input  logic [7:0]       bus_addr,
  input  logic             bus_we,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             ack_valid,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [NS-1:0]    irq
);
  logic [NG*GW-1:0] pins_s;
  logic             ext_s;
  logic [NG*GW-1:0] mask;
  logic [NS-1:0]    ena;
  logic [1:0]       sense_q;
  logic [NS-1:0]    w1c;
  logic [NS-1:0]    flag_q;
  logic [NG-1:0]    grp_hit;
  logic             ext_hit;
  logic [NS-1:0]    set_ev;
  logic             level_mode;

  pcint_sync #(.W(NG*GW), .STAGES(SYNC)) u_sync_pins (
    .clk(clk), .rst(rst), .d(pins), .q(pins_s));

  pcint_sync #(.W(1), .STAGES(SYNC)) u_sync_ext (
    .clk(clk), .rst(rst), .d(ext_pin), .q(ext_s));

  pcint_detect #(.NG(NG), .GW(GW)) u_detect (
    .clk(clk), .rst(rst), .pins_s(pins_s), .ext_s(ext_s), .mask(mask),
    .sense(sense_q), .grp_hit(grp_hit), .ext_hit(ext_hit));

  pcint_regs #(
    .NG(NG), .GW(GW), .TOP_BITS(TOP_BITS), .MASK_ADDR(MASK_ADDR),
    .ENA_ADDR(ENA_ADDR), .FLG_ADDR(FLG_ADDR), .SNS_ADDR(SNS_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .flags_in(flag_q), .mask(mask), .ena(ena), .sense(sense_q), .w1c(w1c),
    .rdata(bus_rdata));

  assign set_ev     = {grp_hit, ext_hit} & ena;
  assign level_mode = (sense_q == pcint_pkg::SENSE_LEVEL);

  for (genvar i = 0; i < NS; i++) begin : g_flag
    logic clr;
    assign clr = w1c[i] | (ack_valid && ack_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst)                    flag_q[i] <= 1'b0;
      else if (set_ev[i])         flag_q[i] <= 1'b1;
      else if (i == 0 && level_mode) flag_q[i] <= 1'b0;
      else if (clr)               flag_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else begin
      for (int i = 1; i < NS; i++) irq[i] <= flag_q[i] & ena[i] & glb_ie;
      irq[0] <= ena[0] & glb_ie & (level_mode ? ~ext_s : flag_q[0]);
    end
  end
endmodule

// File: rtl/pcint_ctrl_chk.sv
module pcint_ctrl_chk #(
  parameter int         NG        = 4,
  parameter int         TOP_BITS  = 7,
  parameter logic [7:0] FLG_ADDR  = 8'h3C,
  parameter logic [7:0] TOP_ADDR  = 8'h73,
  localparam int        NS        = NG + 1,
  localparam int        IDX_W     = $clog2(NS)
) (
  input logic             clk,
  input logic             rst,
  input logic             glb_ie,
  input logic [7:0]       bus_addr,
  input logic             bus_we,
  input logic [7:0]       bus_wdata,
  input logic [7:0]       bus_rdata,
  input logic             ack_valid,
  input logic [IDX_W-1:0] ack_idx,
  input logic [NS-1:0]    irq,
  input logic [NS-1:0]    flag_q,
  input logic [NS-1:0]    set_ev,
  input logic [1:0]       sense_q
);
  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(glb_ie) |-> irq == '0);

  assert_level_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
    sense_q == 2'b00 |=> !flag_q[0]);

  assert_top_mask_bit_R10: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr) == TOP_ADDR |-> (bus_rdata >> TOP_BITS) == 8'd0);

  for (genvar i = 0; i < NS; i++) begin : g_src
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
      set_ev[i] |=> flag_q[i]);

    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (rst)
      bus_we && bus_addr == FLG_ADDR && bus_wdata[i] && !set_ev[i] |=> !flag_q[i]);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
      ack_valid && ack_idx == IDX_W'(i) && !set_ev[i] |=> !flag_q[i]);
  end
endmodule

bind pcint_ctrl pcint_ctrl_chk #(
  .NG(NG), .TOP_BITS(TOP_BITS), .FLG_ADDR(FLG_ADDR),
  .TOP_ADDR(MASK_ADDR[(NG-1)*8 +: 8])
) u_chk (
  .clk(clk), .rst(rst), .glb_ie(glb_ie), .bus_addr(bus_addr),
  .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ack_valid(ack_valid), .ack_idx(ack_idx), .irq(irq), .flag_q(flag_q),
  .set_ev(set_ev), .sense_q(sense_q));

// File: tb/tb_pcint_ctrl.sv
module tb_pcint_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_FLG = 8'h3C, A_ENA = 8'h3D, A_SNS = 8'h69;
  localparam logic [7:0] A_MSK [4] = '{8'h6B, 8'h6C, 8'h6D, 8'h73};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic        ext_pin = 1'b0;
  logic        glb_ie = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ack_valid = 1'b0;
  logic [2:0]  ack_idx = '0;
  logic [4:0]  irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] rv;

  pcint_ctrl dut (
    .clk(clk), .rst(rst), .pins(pins), .ext_pin(ext_pin), .glb_ie(glb_ie),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ack_valid(ack_valid), .ack_idx(ack_idx), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
  end

  initial begin
    idle(3); rst = 1'b0; idle(1);
    // R1: reset state
    for (int g = 0; g < 4; g++) begin
      rd(A_MSK[g], rv); check(rv == 0, "R1 mask reset", rv, 0);
    end
    rd(A_ENA, rv); check(rv == 0, "R1 enable reset", rv, 0);
    rd(A_FLG, rv); check(rv == 0, "R1 flag reset", rv, 0);
    rd(A_SNS, rv); check(rv == 0, "R1 sense reset", rv, 0);
    check(irq == 0, "R1 irq reset", irq, 0);

    // R10: register map and top-group read-only bit
    wr(A_MSK[0], 8'hA1); wr(A_MSK[1], 8'h5C); wr(A_MSK[2], 8'h3E); wr(A_MSK[3], 8'hFF);
    rd(A_MSK[0], rv); check(rv == 8'hA1, "R10 mask0", rv, 8'hA1);
    rd(A_MSK[1], rv); check(rv == 8'h5C, "R10 mask1", rv, 8'h5C);
    rd(A_MSK[2], rv); check(rv == 8'h3E, "R10 mask2", rv, 8'h3E);
    rd(A_MSK[3], rv); check(rv == 8'h7F, "R10 mask3 bit7", rv, 8'h7F);
    rd(8'h00, rv);    check(rv == 0, "R10 unmapped", rv, 0);

    // R2 R3 R4: sweep every pin, mask on/off, enable on/off, both directions
    for (int g = 0; g < 4; g++)
      for (int p = 0; p < 8; p++)
        for (int m = 0; m < 2; m++)
          for (int e = 0; e < 2; e++)
            for (int dir = 0; dir < 2; dir++) begin
              logic [7:0] mv, expf;
              mv = m ? (8'd1 << p) : ~(8'd1 << p);
              wr(A_MSK[g], mv);
              wr(A_ENA, e ? (8'd1 << (g+1)) : 8'd0);
              wr(A_FLG, 8'h1F);
              glb_ie = p[0];
              @(negedge clk); pins[g*8+p] = ~pins[g*8+p];
              idle(6);
              expf = (m && e && !(g == 3 && p == 7)) ? (8'd1 << (g+1)) : 8'd0;
              check(irq == (p[0] ? expf[4:0] : 5'd0), "R4 irq gating", irq,
                    p[0] ? expf[4:0] : 5'd0);
              rd(A_FLG, rv);
              check(rv == expf, (m && e) ? "R2 flag set" : "R3 flag ignored", rv, expf);
            end

    // R4: flag kept but enable dropped -> no request
    wr(A_MSK[0], 8'h01); wr(A_ENA, 8'h02); wr(A_FLG, 8'h1F); glb_ie = 1'b1;
    @(negedge clk); pins[0] = ~pins[0]; idle(6);
    check(irq == 5'h02, "R4 request on", irq, 5'h02);
    wr(A_ENA, 8'h00); idle(2);
    check(irq == 5'h00, "R4 request off", irq, 0);
    rd(A_FLG, rv); check(rv == 8'h02, "R4 flag kept", rv, 8'h02);

    // R5: writing zero keeps, writing one clears
    wr(A_FLG, 8'h00); rd(A_FLG, rv); check(rv == 8'h02, "R5 write zero", rv, 8'h02);
    wr(A_FLG, 8'h02); rd(A_FLG, rv); check(rv == 8'h00, "R5 write one", rv, 0);

    // R6: acknowledge clears only indexed flag
    wr(A_MSK[1], 8'h01); wr(A_ENA, 8'h06);
    @(negedge clk); pins[0] = ~pins[0]; pins[8] = ~pins[8]; idle(6);
    rd(A_FLG, rv); check(rv == 8'h06, "R6 both set", rv, 8'h06);
    @(negedge clk); ack_valid = 1'b1; ack_idx = 3'd7;
    @(negedge clk); ack_valid = 1'b0;
    rd(A_FLG, rv); check(rv == 8'h06, "R6 index out of range", rv, 8'h06);
    @(negedge clk); ack_valid = 1'b1; ack_idx = 3'd1;
    @(negedge clk); ack_valid = 1'b0;
    rd(A_FLG, rv); check(rv == 8'h04, "R6 ack group0", rv, 8'h04);

    // R7: set and write-one-to-clear on the same edge; flag already high
    wr(A_FLG, 8'h1F); wr(A_ENA, 8'h02);
    @(negedge clk); pins[0] = ~pins[0]; idle(6);
    @(negedge clk); pins[0] = ~pins[0];
    @(negedge clk);
    @(negedge clk); bus_addr = A_FLG; bus_wdata = 8'h02; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    idle(3);
    rd(A_FLG, rv); check(rv == 8'h02, "R7 set beats w1c", rv, 8'h02);
    // R7: set and acknowledge on the same edge
    @(negedge clk); pins[0] = ~pins[0];
    @(negedge clk);
    @(negedge clk); ack_valid = 1'b1; ack_idx = 3'd1;
    @(negedge clk); ack_valid = 1'b0;
    idle(3);
    rd(A_FLG, rv); check(rv == 8'h02, "R7 set beats ack", rv, 8'h02);

    // R8: external pin edge senses
    wr(A_ENA, 8'h01); wr(A_FLG, 8'h1F);
    wr(A_SNS, 8'h03);
    @(negedge clk); ext_pin = 1'b1; idle(6);
    rd(A_FLG, rv); check(rv == 8'h01, "R8 rise sense rising", rv, 1);
    wr(A_FLG, 8'h01);
    @(negedge clk); ext_pin = 1'b0; idle(6);
    rd(A_FLG, rv); check(rv == 8'h00, "R8 rise sense falling", rv, 0);
    wr(A_SNS, 8'h02);
    @(negedge clk); ext_pin = 1'b1; idle(6);
    rd(A_FLG, rv); check(rv == 8'h00, "R8 fall sense rising", rv, 0);
    @(negedge clk); ext_pin = 1'b0; idle(6);
    rd(A_FLG, rv); check(rv == 8'h01, "R8 fall sense falling", rv, 1);
    wr(A_FLG, 8'h01); wr(A_SNS, 8'h01);
    @(negedge clk); ext_pin = 1'b1; idle(6);
    rd(A_FLG, rv); check(rv == 8'h01, "R8 any sense rising", rv, 1);
    wr(A_FLG, 8'h01);
    @(negedge clk); ext_pin = 1'b0; idle(6);
    rd(A_FLG, rv); check(rv == 8'h01, "R8 any sense falling", rv, 1);

    // R9: level mode
    wr(A_SNS, 8'h00); idle(2);
    rd(A_FLG, rv); check(rv == 8'h00, "R9 level flag clear", rv, 0);
    check(irq == 5'h01, "R9 level low request", irq, 1);
    @(negedge clk); ext_pin = 1'b1; idle(5);
    check(irq == 5'h00, "R9 level high no request", irq, 0);
    rd(A_FLG, rv); check(rv == 8'h00, "R9 level flag after change", rv, 0);
    glb_ie = 1'b0; @(negedge clk); ext_pin = 1'b0; idle(5);
    check(irq == 5'h00, "R9 level gated by global", irq, 0);

    summary();
  end
endmodule